// File: doc/BRIEF.md
# Serial Controller Setup and Command Sequencer

This block is the host-side front end of a serial controller. It decodes CPU accesses made over an 8-bit bus that has a chip select, read and write strobes, and a select line that chooses between the data register and the control port. A control write can mean three things: a mode word, a sync character or a command. Which one it is depends on where the block stands in its setup sequence.

After a reset, either from the pin or from a command, the block waits for a mode word. If that word selects synchronous operation, the block then takes one or two sync characters, as the mode word asks. Every control write after that is a command. The block holds the mode, sync and command settings and drives them to the serial engines. It also drives the two modem handshake outputs, and it puts the status word together from flags that the transmit and receive paths report.

The serial shifting itself is not part of this block. Its flags arrive as inputs, and received data arrives as a parallel input. A data write raises a one-cycle load pulse towards the transmitter.

Top module: `ser_ctl_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until a mode word is written, cfg_done_o is 0, every command output is 0, dtr_no and rts_no are 1, and bus_oe_o is 0.
- R2: The first control write (cd_i=1) after any reset is taken as the mode word. baud_sel_o shows bits [1:0]. char_bits_o shows 5 plus the value of bits [3:2]. par_en_o shows bit 4, par_even_o shows bit 5, and stop_sel_o shows bits [7:6]. When bits [1:0] are not 00, sync_mode_o is 0 and cfg_done_o rises at once.
- R3: A mode word with bits [1:0]=00 selects synchronous mode. ext_sync_o shows bit 6. If bit 7 is 0, the next two control writes load sync1_o and then sync2_o. If bit 7 is 1, only sync1_o is loaded. cfg_done_o rises only after the last sync character.
- R4: Once setup is complete, a control write is a command. Bit 0 drives tx_en_o, bit 2 rx_en_o, bit 3 send_brk_o and bit 7 hunt_o. Each output takes its new value on the first clock edge at which the write is seen.
- R5: dtr_no is the inverse of command bit 1 and rts_no is the inverse of command bit 5.
- R6: Command bit 4 raises err_clr_o for exactly one cycle, in the cycle after the write edge. The bit is not kept.
- R7: A command with bit 6 set drops cfg_done_o, clears every command output, and makes the next control write a mode word.
- R8: A read with cd_i=1 drives bus_o in the same cycle with the status word: bit 0 tx_rdy_i, bit 1 rx_rdy_i, bit 2 tx_empty_i, bit 3 par_err_i, bit 4 ovr_err_i, bit 5 frm_err_i, bit 6 syn_brk_i, bit 7 the inverse of dsr_ni.
- R9: A read with cd_i=0 drives rx_data_i onto bus_o. A write with cd_i=0 gives a one-cycle tx_load_o pulse, with tx_data_o holding the written byte, and it leaves the setup state unchanged.
- R10: While cs_ni is 1, bus_oe_o is 0 and writes change nothing.
- R11: A write low pulse counts once, however many clock cycles wr_ni stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| cd_i | input | 1 | 1 selects control/status, 0 selects data |
| bus_i | input | 8 | Write data from CPU |
| bus_o | output | 8 | Read data to CPU |
| bus_oe_o | output | 1 | Read bus drive enable |
| rx_data_i | input | 8 | Received character |
| tx_rdy_i | input | 1 | Transmitter ready flag |
| rx_rdy_i | input | 1 | Receiver ready flag |
| tx_empty_i | input | 1 | Transmitter empty flag |
| par_err_i | input | 1 | Parity error flag |
| ovr_err_i | input | 1 | Overrun error flag |
| frm_err_i | input | 1 | Framing error flag |
| syn_brk_i | input | 1 | Sync detect or break flag |
| dsr_ni | input | 1 | Modem ready input, active low |
| dtr_no | output | 1 | Terminal ready output, active low |
| rts_no | output | 1 | Request to send, active low |
| cfg_done_o | output | 1 | Setup sequence complete |
| sync_mode_o | output | 1 | Synchronous mode selected |
| baud_sel_o | output | 2 | Clock factor code |
| char_bits_o | output | 4 | Character length in bits |
| par_en_o | output | 1 | Parity enabled |
| par_even_o | output | 1 | Even parity |
| stop_sel_o | output | 2 | Stop length code (asynchronous) |
| ext_sync_o | output | 1 | External synchronisation |
| one_sync_o | output | 1 | Single sync character |
| sync1_o | output | 8 | First sync character |
| sync2_o | output | 8 | Second sync character |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| send_brk_o | output | 1 | Force break on line |
| hunt_o | output | 1 | Search for sync |
| err_clr_o | output | 1 | Error flag clear pulse |
| tx_load_o | output | 1 | Transmit data load pulse |
| tx_data_o | output | 8 | Byte to transmit |

## Verification
Reads are combinational, so the bench checks bus_o in the same cycle that it asserts rd_ni, shortly after a falling clock edge. Every write is applied at a falling edge and takes effect on the next rising edge. The settings, cfg_done_o and the handshake outputs are therefore checked at the falling edge after that. The err_clr_o and tx_load_o pulses are high in exactly that cycle, so the bench samples them there and again one cycle later to confirm that they have dropped. For a write held low over several cycles, the bench checks the setup progress only after the strobe is released.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int unsigned BW = 8;

  typedef enum logic [1:0] {
    ST_MODE  = 2'd0,
    ST_SYNC1 = 2'd1,
    ST_SYNC2 = 2'd2,
    ST_RUN   = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic       b7;
    logic       b6;
    logic       par_even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] baud;
  } mode_t;

  localparam int unsigned CMD_TXEN = 0;
  localparam int unsigned CMD_DTR  = 1;
  localparam int unsigned CMD_RXEN = 2;
  localparam int unsigned CMD_BRK  = 3;
  localparam int unsigned CMD_ERR  = 4;
  localparam int unsigned CMD_RTS  = 5;
  localparam int unsigned CMD_IRST = 6;
  localparam int unsigned CMD_HUNT = 7;
endpackage

// File: rtl/ser_bus_if.sv
module ser_bus_if
  import ser_ctl_pkg::*;
#(
  parameter int unsigned W = BW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         wr_ni,
  input  logic         cd_i,
  input  logic [W-1:0] bus_i,
  output logic         ctl_wr_o,
  output logic         tx_load_o,
  output logic [W-1:0] tx_data_o
);
  logic wr_q, wr_fall;

  // one event per low pulse
  assign wr_fall  = wr_q & ~wr_ni & ~cs_ni;
  assign ctl_wr_o = wr_fall & cd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b1;
      tx_load_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      wr_q      <= wr_ni;
      tx_load_o <= wr_fall & ~cd_i;
      if (wr_fall && !cd_i) tx_data_o <= bus_i;
    end
  end
endmodule

// File: rtl/ser_setup_fsm.sv
module ser_setup_fsm
  import ser_ctl_pkg::*;
#(
  parameter int unsigned W = BW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_wr_i,
  input  logic [W-1:0] bus_i,
  output logic         cmd_wr_o,
  output mode_t        mode_o,
  output logic [W-1:0] sync1_o,
  output logic [W-1:0] sync2_o,
  output logic         done_o
);
  seq_st_e st_q, st_d;
  mode_t   wmode;

  assign wmode    = mode_t'(bus_i);
  assign cmd_wr_o = ctl_wr_i && (st_q == ST_RUN);
  assign done_o   = (st_q == ST_RUN);

  always_comb begin
    st_d = st_q;
    if (ctl_wr_i) begin
      unique case (st_q)
        ST_MODE:  st_d = (wmode.baud != 2'b00) ? ST_RUN : ST_SYNC1;
        ST_SYNC1: st_d = mode_o.b7 ? ST_RUN : ST_SYNC2;
        ST_SYNC2: st_d = ST_RUN;
        ST_RUN:   st_d = bus_i[CMD_IRST] ? ST_MODE : ST_RUN;
        default:  st_d = ST_MODE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_MODE;
      mode_o  <= '0;
      sync1_o <= '0;
      sync2_o <= '0;
    end else begin
      st_q <= st_d;
      if (ctl_wr_i && st_q == ST_MODE)  mode_o  <= wmode;
      if (ctl_wr_i && st_q == ST_SYNC1) sync1_o <= bus_i;
      if (ctl_wr_i && st_q == ST_SYNC2) sync2_o <= bus_i;
    end
  end
endmodule

// File: rtl/ser_cmd_reg.sv
module ser_cmd_reg
  import ser_ctl_pkg::*;
#(
  parameter int unsigned W = BW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_wr_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] cmd_o,
  output logic         err_clr_o,
  output logic         dtr_no,
  output logic         rts_no
);
  logic [W-1:0] keep_mask;

  // pulse-type bits are never stored
  always_comb begin
    keep_mask = '1;
    keep_mask[CMD_ERR]  = 1'b0;
    keep_mask[CMD_IRST] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      err_clr_o <= 1'b0;
    end else begin
      err_clr_o <= cmd_wr_i & bus_i[CMD_ERR];
      if (cmd_wr_i) cmd_o <= bus_i[CMD_IRST] ? '0 : (bus_i & keep_mask);
    end
  end

  assign dtr_no = ~cmd_o[CMD_DTR];
  assign rts_no = ~cmd_o[CMD_RTS];
endmodule

// File: rtl/ser_stat_mux.sv
module ser_stat_mux
  import ser_ctl_pkg::*;
#(
  parameter int unsigned W = BW
) (
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         cd_i,
  input  logic [W-1:0] rx_data_i,
  input  logic [6:0]   flags_i,
  input  logic         dsr_ni,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o
);
  logic [W-1:0] stat;

  always_comb begin
    stat      = '0;
    stat[6:0] = flags_i;
    stat[7]   = ~dsr_ni;
  end

  assign bus_oe_o = ~cs_ni & ~rd_ni;
  assign bus_o    = !bus_oe_o ? '0 : (cd_i ? stat : rx_data_i);
endmodule

// File: rtl/ser_ctl_seq.sv
module ser_ctl_seq
  import ser_ctl_pkg::*;
#(
  parameter int unsigned W = BW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         wr_ni,
  input  logic         cd_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  input  logic [W-1:0] rx_data_i,
  input  logic         tx_rdy_i,
  input  logic         rx_rdy_i,
  input  logic         tx_empty_i,
  input  logic         par_err_i,
  input  logic         ovr_err_i,
  input  logic         frm_err_i,
  input  logic         syn_brk_i,
  input  logic         dsr_ni,
  output logic         dtr_no,
  output logic         rts_no,
  output logic         cfg_done_o,
  output logic         sync_mode_o,
  output logic [1:0]   baud_sel_o,
  output logic [3:0]   char_bits_o,
  output logic         par_en_o,
  output logic         par_even_o,
  output logic [1:0]   stop_sel_o,
  output logic         ext_sync_o,
  output logic         one_sync_o,
  output logic [W-1:0] sync1_o,
  output logic [W-1:0] sync2_o,
  output logic         tx_en_o,
  output logic         rx_en_o,
  output logic         send_brk_o,
  output logic         hunt_o,
  output logic         err_clr_o,
  output logic         tx_load_o,
  output logic [W-1:0] tx_data_o
);
  localparam logic [3:0] MIN_BITS = 4'd5;

  logic         ctl_wr, cmd_wr;
  mode_t        mode;
  logic [W-1:0] cmd;

  ser_bus_if #(.W(W)) u_bus (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .cd_i, .bus_i,
    .ctl_wr_o(ctl_wr), .tx_load_o, .tx_data_o
  );

  ser_setup_fsm #(.W(W)) u_fsm (
    .clk_i, .rst_ni, .ctl_wr_i(ctl_wr), .bus_i,
    .cmd_wr_o(cmd_wr), .mode_o(mode), .sync1_o, .sync2_o, .done_o(cfg_done_o)
  );

  ser_cmd_reg #(.W(W)) u_cmd (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .bus_i,
    .cmd_o(cmd), .err_clr_o, .dtr_no, .rts_no
  );

  ser_stat_mux #(.W(W)) u_stat (
    .cs_ni, .rd_ni, .cd_i, .rx_data_i,
    .flags_i({syn_brk_i, frm_err_i, ovr_err_i, par_err_i, tx_empty_i, rx_rdy_i, tx_rdy_i}),
    .dsr_ni, .bus_o, .bus_oe_o
  );

  assign sync_mode_o = cfg_done_o && (mode.baud == 2'b00);
  assign baud_sel_o  = mode.baud;
  assign char_bits_o = MIN_BITS + {2'b00, mode.len};
  assign par_en_o    = mode.par_en;
  assign par_even_o  = mode.par_even;
  assign stop_sel_o  = {mode.b7, mode.b6};
  assign ext_sync_o  = mode.b6;
  assign one_sync_o  = mode.b7;
  assign tx_en_o     = cmd[CMD_TXEN];
  assign rx_en_o     = cmd[CMD_RXEN];
  assign send_brk_o  = cmd[CMD_BRK];
  assign hunt_o      = cmd[CMD_HUNT];
endmodule

// File: rtl/ser_ctl_seq_chk.sv
module ser_ctl_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic       cd_i,
  input logic       dsr_ni,
  input logic [7:0] bus_o,
  input logic       bus_oe_o,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       cfg_done_o,
  input logic       tx_en_o,
  input logic       err_clr_o,
  input logic       tx_load_o
);
  p_oe_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !bus_oe_o);
  p_no_wr_effect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable({dtr_no, rts_no, cfg_done_o, tx_en_o}));
  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |=> !err_clr_o);
  p_load_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);
  p_dsr_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && cd_i) |-> (bus_o[7] == !dsr_ni));
  p_idle_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> (dtr_no && rts_no && !tx_en_o));
endmodule

bind ser_ctl_seq ser_ctl_seq_chk u_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .cd_i, .dsr_ni, .bus_o, .bus_oe_o,
  .dtr_no, .rts_no, .cfg_done_o, .tx_en_o, .err_clr_o, .tx_load_o
);

// File: tb/ser_ctl_seq_tb_top.sv
module ser_ctl_seq_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, cd_i = 1'b0;
  logic [7:0] bus_i = '0, rx_data_i = '0;
  logic tx_rdy_i = 0, rx_rdy_i = 0, tx_empty_i = 0, par_err_i = 0;
  logic ovr_err_i = 0, frm_err_i = 0, syn_brk_i = 0, dsr_ni = 1;
  logic [7:0] bus_o, sync1_o, sync2_o, tx_data_o;
  logic bus_oe_o, dtr_no, rts_no, cfg_done_o, sync_mode_o, par_en_o, par_even_o;
  logic ext_sync_o, one_sync_o, tx_en_o, rx_en_o, send_brk_o, hunt_o, err_clr_o, tx_load_o;
  logic [1:0] baud_sel_o, stop_sel_o;
  logic [3:0] char_bits_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  ser_ctl_seq dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_bits(input logic [7:0] m);
    return 4'd5 + {2'b00, m[3:2]};
  endfunction

  function automatic logic [7:0] exp_stat(input logic [6:0] f, input logic dsr_n);
    return {~dsr_n, f};
  endfunction

  task automatic wr(input logic c, input logic [7:0] v, input int hold);
    @(negedge clk_i);
    cs_ni = 0; cd_i = c; bus_i = v; wr_ni = 0;
    repeat (hold) @(negedge clk_i);
    wr_ni = 1; cs_ni = 1;
  endtask

  task automatic chk_mode(input logic [7:0] m);
    chk(baud_sel_o == m[1:0], "R2 baud", baud_sel_o, m[1:0]);
    chk(char_bits_o == exp_bits(m), "R2 bits", char_bits_o, exp_bits(m));
    chk({par_even_o, par_en_o} == m[5:4], "R2 parity", {par_even_o, par_en_o}, m[5:4]);
    chk(stop_sel_o == m[7:6], "R2 stop", stop_sel_o, m[7:6]);
  endtask

  task automatic do_cmd(input logic [7:0] v);
    wr(1, v, 1);
    chk(err_clr_o == v[4], "R6 pulse", err_clr_o, v[4]);
    chk({hunt_o, send_brk_o, rx_en_o, tx_en_o} == {v[7], v[3], v[2], v[0]},
        "R4 cmd", {hunt_o, send_brk_o, rx_en_o, tx_en_o}, {v[7], v[3], v[2], v[0]});
    chk({rts_no, dtr_no} == ~{v[5], v[1]}, "R5 modem", {rts_no, dtr_no}, ~{v[5], v[1]});
    @(negedge clk_i);
    chk(err_clr_o == 0, "R6 drop", err_clr_o, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] m, v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!cfg_done_o && dtr_no && rts_no && !tx_en_o && !bus_oe_o, "R1 in reset", cfg_done_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!cfg_done_o && dtr_no && rts_no && !hunt_o, "R1 after reset", cfg_done_o, 0);

    m = 8'b1111_1110;
    wr(1, m, 1); @(negedge clk_i);
    chk(cfg_done_o == 1, "R2 async done", cfg_done_o, 1);
    chk(sync_mode_o == 0, "R2 async", sync_mode_o, 0);
    chk_mode(m);

    for (int i = 0; i < 24; i++) begin
      v = 8'($urandom) & 8'hBF;
      do_cmd(v);
    end

    // status and data reads
    for (int i = 0; i < 16; i++) begin
      logic [6:0] f;
      logic ds;
      f = 7'($urandom); ds = 1'($urandom); v = 8'($urandom);
      @(negedge clk_i);
      {syn_brk_i, frm_err_i, ovr_err_i, par_err_i, tx_empty_i, rx_rdy_i, tx_rdy_i} = f;
      dsr_ni = ds; rx_data_i = v;
      cs_ni = 0; rd_ni = 0; cd_i = 1;
      #1 chk(bus_oe_o && bus_o == exp_stat(f, ds), "R8 status", bus_o, exp_stat(f, ds));
      cd_i = 0;
      #1 chk(bus_o == v, "R9 rx read", bus_o, v);
      cs_ni = 1; rd_ni = 1;
    end

    // data writes
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom);
      wr(0, v, 1);
      chk(tx_load_o && tx_data_o == v, "R9 load", tx_data_o, v);
      @(negedge clk_i);
      chk(!tx_load_o && cfg_done_o, "R9 no effect", tx_load_o, 0);
    end

    // chip deselected
    do_cmd(8'h21);
    @(negedge clk_i);
    cs_ni = 1; cd_i = 1; bus_i = 8'h40; wr_ni = 0; rd_ni = 0;
    repeat (2) @(negedge clk_i);
    chk(!bus_oe_o, "R10 oe", bus_oe_o, 0);
    wr_ni = 1; rd_ni = 1;
    @(negedge clk_i);
    chk(cfg_done_o && tx_en_o && !rts_no, "R10 ignored", {cfg_done_o, tx_en_o}, 3);

    // internal reset
    wr(1, 8'h40, 1); @(negedge clk_i);
    chk(!cfg_done_o && !tx_en_o && rts_no && dtr_no, "R7 back to mode", cfg_done_o, 0);

    // sync mode, two chars, long write pulse
    m = 8'b0001_1100;
    wr(1, m, 4); @(negedge clk_i);
    chk(!cfg_done_o, "R11 one event", cfg_done_o, 0);
    wr(1, 8'hA5, 3); @(negedge clk_i);
    chk(!cfg_done_o && sync1_o == 8'hA5, "R3 sync1", sync1_o, 8'hA5);
    wr(1, 8'h5A, 1); @(negedge clk_i);
    chk(cfg_done_o && sync2_o == 8'h5A && sync_mode_o, "R3 sync2", sync2_o, 8'h5A);
    chk_mode(m);
    chk(one_sync_o == 0 && ext_sync_o == 0, "R3 two", one_sync_o, 0);

    // single sync char, external sync
    wr(1, 8'h40, 1);
    m = 8'b1100_0000;
    wr(1, m, 1); @(negedge clk_i);
    chk(!cfg_done_o, "R3 wait sync", cfg_done_o, 0);
    wr(1, 8'h3C, 1); @(negedge clk_i);
    chk(cfg_done_o && sync1_o == 8'h3C && one_sync_o && ext_sync_o, "R3 one", sync1_o, 8'h3C);

    // random async re-setup
    for (int i = 0; i < 10; i++) begin
      wr(1, 8'h40, 1);
      m = 8'($urandom);
      if (m[1:0] == 2'b00) m[0] = 1'b1;
      wr(1, m, 1); @(negedge clk_i);
      chk(cfg_done_o, "R7 remode", cfg_done_o, 1);
      chk_mode(m);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule